// File: doc/BRIEF.md
# CAS-before-RAS Refresh Sequencer

This block keeps an asynchronous-strobe DRAM refreshed and brings it up after reset. It generates refresh cycles in which both column strobes fall ahead of the row strobe. The device then takes the row from its own internal counter, so the block never drives a row address. It owns the strobes only while the access controller grants it the bus. It asks for the bus with a level request and holds that request until the grant arrives.

After reset the block waits out the power-up pause. It then asks for the bus and runs the dummy refresh cycles the device needs. Only after the last of these finishes does it raise `init_done_o`, which the access controller uses as its go signal for reads and writes. From then on, a programmable interval timer schedules refreshes. Ticks that arrive while the controller keeps the bus busy are counted, up to a limit. All of them are then serviced back-to-back under one grant.

With the default 100 MHz timing the values are as follows. One refresh is due every 1560 cycles, which keeps 1024 rows inside a 16 ms window. The power-up pause lasts 20000 cycles. Each refresh spends at least 40 ns with RAS high, one cycle with CAS low ahead of RAS, and 60 ns with RAS low. This gives a cycle of at least 110 ns.

Top module: `rfsh_cbr_seq`

## Requirements
- R1: While reset is applied and on the first cycle after it, `req_o` and `init_done_o` are 0, and `ras_n_o`, both bits of `cas_n_o` and `we_n_o` are 1.
- R2: `req_o` stays 0 for the first PWRUP_CYC-1 clock edges after reset release and is 1 after edge PWRUP_CYC.
- R3: Exactly INIT_REFS refresh cycles (RAS falling edges) occur before `init_done_o` rises. Once high, `init_done_o` stays high until reset.
- R4: In every refresh cycle, both CAS bits fall together and stay low for exactly CAS_LEAD_CYC cycles before RAS falls.
- R5: RAS is high for at least PRE_CYC cycles before each falling edge and stays low for exactly RAS_LOW_CYC cycles.
- R6: A strobe is driven low only in cycles where both `req_o` and `gnt_i` are 1. With no grant, all strobes stay high.
- R7: `we_n_o` is 1 in every cycle.
- R8: After initialisation, one refresh is scheduled every INTERVAL_CYC cycles. A raised `req_o` stays 1 until `gnt_i` is seen.
- R9: Up to BACKLOG_MAX pending refreshes accumulate while the grant is withheld. They are all serviced under one grant before `req_o` drops. Further ticks beyond that limit are dropped.
- R10: RAS and both CAS bits return high in the same cycle at the end of each refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gnt_i | input | 1 | Bus grant from the access controller; held while `req_o` is high |
| req_o | output | 1 | Bus request to the access controller |
| init_done_o | output | 1 | Power-up sequence complete; normal accesses may start |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 2 | Column strobes, upper in bit 1 and lower in bit 0, active low |
| we_n_o | output | 1 | Write enable, active low, held inactive |

## Verification
The assertions check several properties on every cycle:
- CAS is low on the cycle before each RAS fall.
- All strobes release together, and RAS low lasts its exact length.
- Strobes never go active without a grant.
- An ungranted request does not drop.
- `init_done_o` never falls, and the backlog stays within its bound.

Only the bench scenarios can show the properties that depend on counts over long windows:
- The exact length of the power-up pause.
- The number of dummy cycles.
- The average refresh rate over ten intervals.
- The saturation and back-to-back draining of the backlog.
- Recovery from a reset taken in mid-operation.

// File: rtl/rfsh_cbr_pkg.sv
package rfsh_cbr_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_CAS, PH_RAS} cyc_ph_e;
  typedef enum logic [1:0] {ST_PWRUP, ST_IDLE, ST_REQ, ST_CYC} ctl_st_e;
endpackage

// File: rtl/rfsh_cbr_timer.sv
module rfsh_cbr_timer #(
  parameter int INTERVAL_CYC = 1560,
  parameter int BACKLOG_MAX  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic take_i,
  output logic pend_o
);
  localparam int TW = $clog2(INTERVAL_CYC);
  localparam int BW = $clog2(BACKLOG_MAX + 1);

  logic [TW-1:0] tmr;
  logic [BW-1:0] backlog;
  logic          tick, inc;

  assign tick   = en_i && (tmr == '0);
  // a saturated backlog still takes a tick if a refresh retires the same cycle
  assign inc    = tick && ((backlog != BW'(BACKLOG_MAX)) || take_i);
  assign pend_o = (backlog != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr <= TW'(INTERVAL_CYC - 1);
    end else if (!en_i || tick) begin
      tmr <= TW'(INTERVAL_CYC - 1);
    end else begin
      tmr <= tmr - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      backlog <= '0;
    end else begin
      case ({inc, take_i})
        2'b10:   backlog <= backlog + 1'b1;
        2'b01:   backlog <= backlog - 1'b1;
        default: backlog <= backlog;
      endcase
    end
  end

  a_r9_backlog_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    backlog <= BW'(BACKLOG_MAX));
  a_r9_take_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> pend_o);
endmodule

// File: rtl/rfsh_cbr_cycle.sv
module rfsh_cbr_cycle
  import rfsh_cbr_pkg::*;
#(
  parameter int PRE_CYC      = 4,
  parameter int CAS_LEAD_CYC = 1,
  parameter int RAS_LOW_CYC  = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int CW = $clog2(PRE_CYC + CAS_LEAD_CYC + RAS_LOW_CYC + 1);

  cyc_ph_e       ph;
  logic [CW-1:0] cnt;

  assign busy_o  = (ph != PH_IDLE);
  assign done_o  = (ph == PH_RAS) && (cnt == '0);
  assign cas_n_o = !((ph == PH_CAS) || (ph == PH_RAS));
  assign ras_n_o = (ph != PH_RAS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start_i) begin
          ph  <= PH_PRE;
          cnt <= CW'(PRE_CYC - 1);
        end
        PH_PRE: if (cnt == '0) begin
          ph  <= PH_CAS;
          cnt <= CW'(CAS_LEAD_CYC - 1);
        end else cnt <= cnt - 1'b1;
        PH_CAS: if (cnt == '0) begin
          ph  <= PH_RAS;
          cnt <= CW'(RAS_LOW_CYC - 1);
        end else cnt <= cnt - 1'b1;
        PH_RAS: if (cnt == '0) begin
          ph <= PH_IDLE;
        end else cnt <= cnt - 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // independent run-length counter for the RAS low window
  logic [CW-1:0] chk_lo;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      chk_lo <= '0;
    else if (ras_n_o) chk_lo <= '0;
    else              chk_lo <= chk_lo + 1'b1;
  end

  a_r4_cas_leads_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> $past(!cas_n_o));
  a_r10_release_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> cas_n_o);
  a_r5_ras_low_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (chk_lo == CW'(RAS_LOW_CYC)));
endmodule

// File: rtl/rfsh_cbr_seq.sv
module rfsh_cbr_seq
  import rfsh_cbr_pkg::*;
#(
  parameter int PWRUP_CYC    = 20000,
  parameter int INTERVAL_CYC = 1560,
  parameter int INIT_REFS    = 8,
  parameter int BACKLOG_MAX  = 8,
  parameter int PRE_CYC      = 4,
  parameter int CAS_LEAD_CYC = 1,
  parameter int RAS_LOW_CYC  = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       gnt_i,
  output logic       req_o,
  output logic       init_done_o,
  output logic       ras_n_o,
  output logic [1:0] cas_n_o,
  output logic       we_n_o
);
  localparam int PW = $clog2(PWRUP_CYC);
  localparam int IW = $clog2(INIT_REFS + 1);

  ctl_st_e       st;
  logic [PW-1:0] pw_cnt;
  logic [IW-1:0] init_cnt;
  logic          init_done_q;
  logic          pend, more, take;
  logic          seq_start, seq_busy, seq_done, seq_ras_n, seq_cas_n;

  assign more      = !init_done_q || pend;
  assign take      = seq_done && init_done_q;
  assign seq_start = ((st == ST_REQ) && gnt_i) ||
                     ((st == ST_CYC) && !seq_busy && more);

  assign req_o       = (st == ST_REQ) || (st == ST_CYC);
  assign init_done_o = init_done_q;
  assign ras_n_o     = seq_ras_n;
  assign cas_n_o     = {2{seq_cas_n}};
  assign we_n_o      = 1'b1;

  rfsh_cbr_timer #(
    .INTERVAL_CYC(INTERVAL_CYC),
    .BACKLOG_MAX (BACKLOG_MAX)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (init_done_q),
    .take_i(take),
    .pend_o(pend)
  );

  rfsh_cbr_cycle #(
    .PRE_CYC     (PRE_CYC),
    .CAS_LEAD_CYC(CAS_LEAD_CYC),
    .RAS_LOW_CYC (RAS_LOW_CYC)
  ) u_cycle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(seq_start),
    .busy_o (seq_busy),
    .done_o (seq_done),
    .ras_n_o(seq_ras_n),
    .cas_n_o(seq_cas_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st          <= ST_PWRUP;
      pw_cnt      <= PW'(PWRUP_CYC - 1);
      init_cnt    <= '0;
      init_done_q <= 1'b0;
    end else begin
      case (st)
        ST_PWRUP: if (pw_cnt == '0) st <= ST_REQ;
                  else pw_cnt <= pw_cnt - 1'b1;
        ST_IDLE:  if (pend) st <= ST_REQ;
        ST_REQ:   if (gnt_i) st <= ST_CYC;
        ST_CYC:   if (!seq_busy && !more) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
      if (seq_done && !init_done_q) begin
        if (init_cnt == IW'(INIT_REFS - 1)) init_done_q <= 1'b1;
        else init_cnt <= init_cnt + 1'b1;
      end
    end
  end

  a_r6_strobes_need_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ras_n_o && (&cas_n_o)) |-> (gnt_i && req_o));
  a_r8_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i) |=> req_o);
  a_r3_init_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
endmodule

// File: tb/rfsh_cbr_seq_test.sv
module rfsh_cbr_seq_test;
  localparam int PWRUP    = 50;
  localparam int INTERVAL = 300;
  localparam int INITN    = 8;
  localparam int BKMAX    = 8;
  localparam int PRE      = 4;
  localparam int LEAD     = 1;
  localparam int RLOW     = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gnt = 1'b0;
  logic       auto_gnt = 1'b0;
  logic       req, init_done, ras_n, we_n;
  logic [1:0] cas_n;

  int checks = 0, fails = 0;
  int mon_checks = 0, mon_fails = 0;
  int ras_falls = 0;

  always #4 clk = ~clk;

  rfsh_cbr_seq #(
    .PWRUP_CYC(PWRUP), .INTERVAL_CYC(INTERVAL), .INIT_REFS(INITN),
    .BACKLOG_MAX(BKMAX), .PRE_CYC(PRE), .CAS_LEAD_CYC(LEAD), .RAS_LOW_CYC(RLOW)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .gnt_i(gnt), .req_o(req),
    .init_done_o(init_done), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n)
  );

  // access-controller model: grants whenever asked, if enabled
  always @(negedge clk) gnt <= auto_gnt ? req : 1'b0;

  // strobe monitor
  logic prev_ras = 1'b1;
  int hi_run = 0, lo_run = 0, cas_run = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ras = 1'b1; hi_run = 0; lo_run = 0; cas_run = 0;
    end else begin
      if (prev_ras && !ras_n) begin
        ras_falls++;
        mon_checks += 2;
        if (cas_n != 2'b00 || cas_run != LEAD) begin
          mon_fails++;
          $display("FAIL R4 cas lead: cas_n=%b run=%0d expected 00 run=%0d", cas_n, cas_run, LEAD);
        end
        if (hi_run < PRE) begin
          mon_fails++;
          $display("FAIL R5 precharge: %0d cycles expected >=%0d", hi_run, PRE);
        end
      end
      if (!prev_ras && ras_n) begin
        mon_checks += 2;
        if (lo_run != RLOW) begin
          mon_fails++;
          $display("FAIL R5 ras low: %0d cycles expected %0d", lo_run, RLOW);
        end
        if (cas_n != 2'b11) begin
          mon_fails++;
          $display("FAIL R10 release: cas_n=%b expected 11", cas_n);
        end
      end
      mon_checks += 3;
      if (cas_n[0] != cas_n[1]) begin
        mon_fails++;
        $display("FAIL R4 cas split: cas_n=%b expected equal bits", cas_n);
      end
      if (!we_n) begin
        mon_fails++;
        $display("FAIL R7 we_n=%b expected 1", we_n);
      end
      if (!(gnt && req) && !(ras_n && (&cas_n))) begin
        mon_fails++;
        $display("FAIL R6 strobes active without grant: ras_n=%b cas_n=%b expected 1/11", ras_n, cas_n);
      end
      hi_run  = ras_n ? hi_run + 1 : 0;
      lo_run  = ras_n ? 0 : lo_run + 1;
      cas_run = (cas_n == 2'b00) ? cas_run + 1 : 0;
      prev_ras = ras_n;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    step(); step();
    check(req == 1'b0, "R1 req in reset", int'(req), 0);
    check(init_done == 1'b0, "R1 init_done in reset", int'(init_done), 0);
    check({ras_n, cas_n, we_n} == 4'hF, "R1 strobes in reset", int'({ras_n, cas_n, we_n}), 15);
  endtask

  task automatic t_powerup();
    int n = 0;
    rst_n = 1'b1;
    step(); n = 1;
    check(req == 1'b0 && {ras_n, cas_n, we_n} == 4'hF, "R1 first cycle after reset",
          int'({req, ras_n, cas_n, we_n}), 15);
    while (!req && n < PWRUP + 20) begin step(); n++; end
    check(n == PWRUP, "R2 power-up pause edges", n, PWRUP);
    check(init_done == 1'b0, "R3 not done at first request", int'(init_done), 0);
  endtask

  task automatic t_init();
    int base = ras_falls;
    int n = 0;
    auto_gnt = 1'b1;
    while (!init_done && n < 2000) begin step(); n++; end
    check(init_done == 1'b1, "R3 init_done raised", int'(init_done), 1);
    check(ras_falls - base == INITN, "R3 dummy refresh count", ras_falls - base, INITN);
    repeat (20) step();
    check(ras_falls - base == INITN && req == 1'b0, "R3 no extra cycles after init",
          ras_falls - base, INITN);
    check(init_done == 1'b1, "R3 init_done sticky", int'(init_done), 1);
  endtask

  task automatic t_interval();
    int base = ras_falls;
    repeat (10 * INTERVAL) step();
    check(ras_falls - base >= 9 && ras_falls - base <= 11, "R8 refreshes in 10 intervals",
          ras_falls - base, 10);
  endtask

  task automatic t_backlog();
    int base, n = 0, drops = 0;
    while (req) step();
    auto_gnt = 1'b0;
    while (!req && n < 2 * INTERVAL) begin step(); n++; end
    check(req == 1'b1, "R8 request raised on tick", int'(req), 1);
    base = ras_falls;
    repeat (11 * INTERVAL) begin
      step();
      if (!req) drops++;
    end
    check(drops == 0, "R8 request held without grant", drops, 0);
    check(ras_falls == base, "R6 no refresh without grant", ras_falls - base, 0);
    auto_gnt = 1'b1;
    step();
    n = 0;
    while (req && n < 4 * INTERVAL) begin step(); n++; end
    check(ras_falls - base >= BKMAX && ras_falls - base <= BKMAX + 1,
          "R9 backlog drained under one grant", ras_falls - base, BKMAX);
    check(req == 1'b0, "R9 request drops after drain", int'(req), 0);
  endtask

  task automatic t_mid_reset();
    int n = 0;
    while (ras_n && n < 2 * INTERVAL) begin step(); n++; end
    rst_n = 1'b0;
    step();
    check(req == 1'b0 && init_done == 1'b0, "R1 mid-run reset outputs",
          int'({req, init_done}), 0);
    check({ras_n, cas_n, we_n} == 4'hF, "R1 mid-run reset strobes", int'({ras_n, cas_n, we_n}), 15);
    step();
    rst_n = 1'b1;
    n = 0;
    while (!req && n < PWRUP + 20) begin step(); n++; end
    check(n == PWRUP, "R2 pause after second reset", n, PWRUP);
  endtask

  initial begin
    t_reset_state();
    t_powerup();
    t_init();
    t_interval();
    t_backlog();
    t_mid_reset();
    repeat (5) step();
    $display("== %0d vectors applied, %0d miscompares ==", checks + mon_checks, fails + mon_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks + mon_checks + 1, fails + mon_fails + 1);
    $finish;
  end
endmodule